// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two 64-bit packed-integer operands lane by lane for a multimedia execution unit. A size select splits the operands into byte, halfword or word lanes, and no carry crosses from one lane into the next. A mode select picks how each lane's sum is finished:

- wraparound keeps the low bits;
- unsigned saturation clamps to the unsigned lane range;
- signed saturation clamps to the two's-complement lane range;
- mixed mode adds an unsigned first operand to a signed second operand and clamps to the unsigned range.

A per-byte flag vector reports which lanes clamped.

Operands enter through a valid/ready input stream and results leave through a valid/ready output stream, with one register stage in between. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. The output holds its payload for as long as `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the stage is empty or the stage is being drained in the same cycle. This gives full throughput under no back-pressure and no lost or duplicated items under back-pressure.

Top module: `simd_sat_adder`

## Requirements
- R1: `in_size` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, and 3 behaves as 8-bit lanes. A carry never passes from one lane into the next.
- R2: With `in_mode` = 0 (wraparound), each lane holds the sum modulo 2^W and all saturation flags are 0.
- R3: With `in_mode` = 1 (unsigned saturation), both lanes are unsigned. A sum above 2^W-1 gives all ones in the lane and sets its flag.
- R4: With `in_mode` = 2 (signed saturation), both lanes are two's complement. A sum above 2^(W-1)-1 gives 0 followed by ones, a sum below -2^(W-1) gives 1 followed by zeros, and either case sets the flag.
- R5: With `in_mode` = 3 (mixed), the `in_a` lane is unsigned and the `in_b` lane is signed. A true sum below 0 gives 0, a true sum above 2^W-1 gives all ones, and either case sets the flag.
- R6: `out_sat[i]` is the clamp flag of the lane that covers bits 8i+7..8i. All bytes of a wider lane carry the same flag.
- R7: An input accepted at a rising edge appears on `out_valid`/`out_sum`/`out_sat` right after that edge, which is exactly one cycle of latency.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady. `in_ready` equals `!out_valid || out_ready`. Every accepted input is delivered once, in order.
- R9: `in_mode` codes 4 to 7 behave as wraparound (R2).
- R10: While `rst_n` is low, `out_valid` is 0. After reset, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Stage can take a beat |
| in_a | input | 64 | First operand (unsigned in mixed mode) |
| in_b | input | 64 | Second operand (signed in mixed mode) |
| in_size | input | 2 | Lane width code |
| in_mode | input | 3 | Arithmetic mode code |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_sum | output | 64 | Packed lane results |
| out_sat | output | 8 | Per-byte clamp flags |

## Verification
The hardest cases to reach are the sums that land exactly on a lane's boundaries. These include the most negative signed lane plus a small negative value, and in mixed mode an unsigned value so large that only a positive signed operand pushes it over. They also include carries that would cross into a neighbouring lane at 16 and 32 bits. Directed beats set these edge values in one lane and a value that would show leakage in the neighbour.

A long run of random beats then mixes edge-biased operands with random back-pressure on `out_ready`. This keeps the stage full while new beats wait, so stalled results must survive untouched.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [2:0] MD_WRAP = 3'd0;
  localparam logic [2:0] MD_USAT = 3'd1;
  localparam logic [2:0] MD_SSAT = 3'd2;
  localparam logic [2:0] MD_MIX  = 3'd3;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   mode,
  output logic [W-1:0] res,
  output logic         clamp
);
  import simd_pkg::*;
  logic [W:0]   us;
  logic [W:0]   ss;
  logic [W+1:0] ms;

  always_comb begin
    us = {1'b0, a} + {1'b0, b};
    ss = {a[W-1], a} + {b[W-1], b};
    ms = {2'b00, a} + {{2{b[W-1]}}, b};
    res   = us[W-1:0];
    clamp = 1'b0;
    case (mode)
      MD_USAT: begin
        if (us[W]) begin
          res   = '1;
          clamp = 1'b1;
        end
      end
      MD_SSAT: begin
        res = ss[W-1:0];
        if (ss[W] != ss[W-1]) begin
          clamp = 1'b1;
          res   = ss[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
      end
      MD_MIX: begin
        res = ms[W-1:0];
        if (ms[W+1]) begin
          res   = '0;
          clamp = 1'b1;
        end else if (ms[W]) begin
          res   = '1;
          clamp = 1'b1;
        end
      end
      default: begin
        res   = us[W-1:0];
        clamp = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/simd_width_bank.sv
module simd_width_bank #(
  parameter int DATA_W = 64,
  parameter int W      = 8
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [2:0]          mode,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W/8-1:0] flags
);
  localparam int LANES = DATA_W / W;
  localparam int BPL   = W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic clamp_l;
    simd_lane_add #(.W(W)) u_lane (
      .a     (a[l*W +: W]),
      .b     (b[l*W +: W]),
      .mode  (mode),
      .res   (res[l*W +: W]),
      .clamp (clamp_l)
    );
    assign flags[l*BPL +: BPL] = {BPL{clamp_l}};
  end
endmodule

// File: rtl/simd_stage_reg.sv
module simd_stage_reg #(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [FLAG_W-1:0] s_flag,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [FLAG_W-1:0] m_flag
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_flag  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_data <= s_data;
        m_flag <= s_flag;
      end
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic [1:0]          in_size,
  input  logic [2:0]          in_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_sum,
  output logic [DATA_W/8-1:0] out_sat
);
  import simd_pkg::*;
  localparam int FLAG_W = DATA_W / BYTE_W;
  localparam int NWID   = 3;

  logic [DATA_W-1:0] bank_res [NWID];
  logic [FLAG_W-1:0] bank_flg [NWID];
  logic [DATA_W-1:0] sel_res;
  logic [FLAG_W-1:0] sel_flg;

  for (genvar k = 0; k < NWID; k++) begin : g_bank
    simd_width_bank #(.DATA_W(DATA_W), .W(8 << k)) u_bank (
      .a     (in_a),
      .b     (in_b),
      .mode  (in_mode),
      .res   (bank_res[k]),
      .flags (bank_flg[k])
    );
  end

  always_comb begin
    case (in_size)
      SZ_HALF: begin sel_res = bank_res[1]; sel_flg = bank_flg[1]; end
      SZ_WORD: begin sel_res = bank_res[2]; sel_flg = bank_flg[2]; end
      default: begin sel_res = bank_res[0]; sel_flg = bank_flg[0]; end
    endcase
  end

  simd_stage_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (sel_res),
    .s_flag  (sel_flg),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_sum),
    .m_flag  (out_sat)
  );
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [1:0]          in_size,
  input logic [2:0]          in_mode,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_sum,
  input logic [DATA_W/8-1:0] out_sat
);
  logic take;
  assign take = in_valid && in_ready;

  a_r10_reset_idle: assert property (@(posedge clk) !rst_n |-> !out_valid);

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_sat)));

  a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r2_wrap_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_mode == 3'd0 || in_mode[2])) |=> (out_sat == '0));

  a_r6_half_group: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_size == 2'd1) |=> (out_sat[1] == out_sat[0]));

  a_r6_word_group: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_size == 2'd2) |=> ($countones(out_sat[3:0]) == 0 || out_sat[3:0] == 4'hF));

  a_r3_usat_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 3'd1) |=> (!out_sat[0] || out_sum[7:0] == 8'hFF));

  a_r5_mix_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 3'd3) |=> (!out_sat[0] || out_sum[7:0] == 8'hFF || out_sum[7:0] == 8'h00));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_size   (in_size),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_sat   (out_sat)
);

// File: tb/sim_simd_sat_adder.sv
module sim_simd_sat_adder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_sum;
  logic [7:0]  out_sat;

  int tests = 0;
  int fails = 0;
  int pushed = 0;
  int popped = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] sum;
    logic [7:0]  sat;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_adder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_size(in_size), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_sat(out_sat)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] sz, input logic [2:0] md,
                                output logic [63:0] s, output logic [7:0] f);
    int w;
    longint mx, hmax, hmin, ua, ub, sa, sb2, t;
    bit cl;
    w = (sz == 2'd1) ? 16 : (sz == 2'd2) ? 32 : 8;
    mx = (longint'(1) << w) - 1;
    hmax = (longint'(1) << (w - 1)) - 1;
    hmin = -(longint'(1) << (w - 1));
    s = '0;
    f = '0;
    for (int l = 0; l < 64 / w; l++) begin
      ua = longint'((a >> (l * w)) & 64'(mx));
      ub = longint'((b >> (l * w)) & 64'(mx));
      sa = (ua > hmax) ? ua - (mx + 1) : ua;
      sb2 = (ub > hmax) ? ub - (mx + 1) : ub;
      cl = 1'b0;
      case (md)
        3'd1: begin t = ua + ub; if (t > mx) begin t = mx; cl = 1'b1; end end
        3'd2: begin
          t = sa + sb2;
          if (t > hmax) begin t = hmax; cl = 1'b1; end
          else if (t < hmin) begin t = hmin; cl = 1'b1; end
        end
        3'd3: begin
          t = ua + sb2;
          if (t < 0) begin t = 0; cl = 1'b1; end
          else if (t > mx) begin t = mx; cl = 1'b1; end
        end
        default: t = ua + ub;
      endcase
      s |= (64'(t) & 64'(mx)) << (l * w);
      for (int k = 0; k < w / 8; k++) f[l * (w / 8) + k] = cl;
    end
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] sz, input logic [2:0] md, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_size = sz; in_mode = md;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model(a, b, sz, md, e.sum, e.sat);
    e.tag = tag;
    sb.push_back(e);
    pushed++;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected output", out_sum, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          popped++;
          check(out_sum == e.sum, {e.tag, " sum"}, out_sum, e.sum);
          check(out_sat == e.sat, {e.tag, " R6 flags"}, 64'(out_sat), 64'(e.sat));
        end
      end
      out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [63:0] edgy();
    case ($urandom_range(0, 4))
      0: return 64'hFFFF_FFFF_FFFF_FFFF;
      1: return 64'h8000_8000_8000_8080;
      2: return 64'h7FFF_FFFF_7FFF_7F7F;
      3: return 64'h0;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);

    send(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 3'd0, "R1 R2 byte wrap");
    #1;
    check(out_valid == 1'b1, "R7 latency", 64'(out_valid), 64'd1);
    send(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 3'd0, "R1 half carry cut");
    send(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd2, 3'd0, "R1 word carry cut");
    send(64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_2020_2020, 2'd3, 3'd1, "R1 R3 size3 usat");
    send(64'hFFFF_0000_8000_0001, 64'h0001_0000_8000_0001, 2'd1, 3'd1, "R3 half usat");
    send(64'h7F80_7F80_0000_0000, 64'h0180_0000_0000_0000, 2'd0, 3'd2, "R4 byte ssat");
    send(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'd2, 3'd2, "R4 word ssat");
    send(64'h0005_FFFF_00FF_0010, 64'hFFF0_0001_0001_FFF0, 2'd1, 3'd3, "R5 half mixed");
    send(64'h0000_FF01_00F0_FF00, 64'h0000_7F80_8010_0180, 2'd0, 3'd3, "R5 byte mixed");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 3'd5, "R9 mode5 wrap");
    send(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 3'd7, "R9 mode7 wrap");

    bp_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send(edgy(), edgy(), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), "R8 random stalled");
    end
    idle();
    bp_on = 1'b0;
    for (int i = 0; i < 100 && sb.size() != 0; i++) @(negedge clk);
    check(pushed == popped, "R8 R7 delivered count", 64'(popped), 64'(pushed));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule